// File: doc/BRIEF.md
# Soft-Start Ramp Sequencer

This block brings one output rail through start-up. It holds a shared run line low while its own start-up conditions are unmet: local initialisation is not finished, or the input supply is below its turn-on level. The line is wired-AND across several devices, so none of them starts until every device has let go. Once the sensed line is high and the block is enabled, it counts a programmed turn-on delay. It then raises a digital target-voltage code from zero to the commanded set point in equal time steps.

All delay and ramp timing is counted in ticks of a shared timebase input rather than the local clock. Devices on one shared timebase therefore step together. The tick is the synchronised rising edge of that input, and one tick is meant to be 0.1 ms. The rise time in ticks equals the number of ramp steps. A rise time too short to be a useful ramp skips the ramp, and the target goes straight to the set point.

During the ramp the block asks the power stage for discontinuous conduction, so that the rail can start into a pre-biased load. Delay, rise time and set point are sampled once, when the block leaves its idle state. The sensed run line is taken to be already in the clock domain.

Top module: `softstart_seq`

## Requirements
- R1: `run_pull_low_o` is 1 (pull the shared line low) whenever `init_done_i` or `vin_ok_i` is 0, and 0 when both are 1.
- R2: After leaving idle, the block starts no delay and no ramp while `run_i` is low. `vtarget_o` stays 0 and `ramp_active_o` stays 0 until the line is sensed high.
- R3: `share_clk_i` passes through a two-flop synchroniser. Each rising edge yields a one-cycle tick two clocks later, and the delay and ramp advance only on ticks.
- R4: Once the line is sensed high, the block counts the latched delay D in ticks before it leaves the delay phase. D = 0 leaves on the next clock.
- R5: For a latched rise time N ≥ 3, the ramp takes exactly N ticks. After tick k, `vtarget_o` equals floor(S·k/N), where S is the latched set point, and the target changes only on a tick.
- R6: The target never exceeds S, never decreases within a ramp, and lands exactly on S at the last step.
- R7: For N < 3 (under 0.25 ms), the ramp is skipped. `vtarget_o` goes from 0 straight to S when the delay ends, and `ramp_active_o` never rises.
- R8: `ramp_active_o` and `dcm_req_o` are both 1 for exactly the cycles of the ramp phase, and 0 otherwise.
- R9: `done_o` pulses for one cycle, in the first cycle in which `vtarget_o` shows S after a start.
- R10: After leaving idle, `en_i` low returns the block to idle with `vtarget_o` = 0 on the next cycle. Past the wait phase, `run_i` low does the same.
- R11: Changes to `dly_cfg_i`, `rise_cfg_i` and `vset_cfg_i` after the block has left idle have no effect on that start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Start request; low aborts to idle |
| init_done_i | input | 1 | Local initialisation finished |
| vin_ok_i | input | 1 | Input supply above turn-on threshold |
| run_i | input | 1 | Sensed level of the shared run line |
| share_clk_i | input | 1 | Shared timebase, one rising edge per 0.1 ms |
| dly_cfg_i | input | 16 | Turn-on delay in ticks |
| rise_cfg_i | input | 16 | Rise time in ticks (= step count) |
| vset_cfg_i | input | 16 | Commanded set-point code |
| run_pull_low_o | output | 1 | Drive the shared run line low |
| vtarget_o | output | 16 | Target-voltage code |
| ramp_active_o | output | 1 | Ramp phase in progress |
| dcm_req_o | output | 1 | Discontinuous-mode request to the power stage |
| done_o | output | 1 | One-cycle pulse when the target reaches the set point |

## Verification
The bench builds the block with its default parameters: 16-bit time and code widths, a two-stage synchroniser and a 3-tick minimum rise time. It runs the shared timebase at six clocks per tick. At that rate a 1000-step ramp to full-scale code fits in the run, alongside short ramps with fractional step sizes. The 2- and 3-tick rise times sit on either side of the skip threshold, and both are exercised. A peer device holding the wired-AND line low reaches the wait and abort paths.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    SS_IDLE  = 3'd0,
    SS_WAIT  = 3'd1,
    SS_DELAY = 3'd2,
    SS_RAMP  = 3'd3,
    SS_ON    = 3'd4
  } ss_state_e;

  // whole part of the per-step increment (0 when no steps)
  function automatic logic [15:0] step_base(input logic [15:0] vset,
                                            input logic [15:0] steps);
    if (steps == '0) return '0;
    return vset / steps;
  endfunction

  // fractional part, carried in units of 1/steps
  function automatic logic [15:0] step_frac(input logic [15:0] vset,
                                            input logic [15:0] steps);
    if (steps == '0) return '0;
    return vset % steps;
  endfunction

endpackage

// File: rtl/ss_tick_sync.sv
module ss_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic tick_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= async_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[g] <= 1'b0;
      else        sh_q[g] <= sh_q[g-1];
    end
  end

  assign tick_o = sh_q[LAST-1] & ~sh_q[LAST];

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/ss_delay_cnt.sv
module ss_delay_cnt #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)          cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  delay_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !$past(clear_i) && cnt_q != $past(cnt_q)) |-> $past(tick_i));

endmodule

// File: rtl/ss_ramp_acc.sv
module ss_ramp_acc #(
  parameter int VW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          jump_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [VW-1:0] vset_i,
  input  logic [TW-1:0] steps_i,
  output logic [VW-1:0] target_o,
  output logic          last_o
);
  import ss_pkg::*;

  logic [VW-1:0] base_q, tgt_q;
  logic [TW-1:0] rem_q, frac_q, k_q;
  logic [TW:0]   frac_sum;
  logic          carry;

  assign frac_sum = {1'b0, frac_q} + {1'b0, rem_q};
  assign carry    = (frac_sum >= {1'b0, steps_i});
  assign last_o   = (k_q + 1'b1 == steps_i);
  assign target_o = tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; rem_q <= '0; frac_q <= '0; k_q <= '0; tgt_q <= '0;
    end else if (clear_i) begin
      tgt_q <= '0;
    end else if (jump_i) begin
      tgt_q <= vset_i;
    end else if (load_i) begin
      base_q <= step_base(vset_i, steps_i);
      rem_q  <= step_frac(vset_i, steps_i);
      frac_q <= '0;
      k_q    <= '0;
      tgt_q  <= '0;
    end else if (step_i) begin
      k_q <= k_q + 1'b1;
      if (carry) begin
        frac_q <= TW'(frac_sum - {1'b0, steps_i});
        tgt_q  <= tgt_q + base_q + 1'b1;
      end else begin
        frac_q <= frac_sum[TW-1:0];
        tgt_q  <= tgt_q + base_q;
      end
    end
  end

  // R6
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_q <= vset_i);

  // R6
  monotone_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> tgt_q >= $past(tgt_q));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int TW          = 16,
  parameter int VW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RISE    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          init_done_i,
  input  logic          vin_ok_i,
  input  logic          run_i,
  input  logic          share_clk_i,
  input  logic [TW-1:0] dly_cfg_i,
  input  logic [TW-1:0] rise_cfg_i,
  input  logic [VW-1:0] vset_cfg_i,
  output logic          run_pull_low_o,
  output logic [VW-1:0] vtarget_o,
  output logic          ramp_active_o,
  output logic          dcm_req_o,
  output logic          done_o
);
  import ss_pkg::*;

  localparam logic [TW-1:0] MIN_RISE_C = TW'(MIN_RISE);

  ss_state_e     state_q, state_d;
  logic [TW-1:0] dly_l, rise_l;
  logic [VW-1:0] vset_l;
  logic          tick, dly_expired, last_step;
  logic          acc_clear, acc_jump, acc_load, acc_step;
  logic          done_d, done_q, abort_run;

  assign run_pull_low_o = ~(init_done_i & vin_ok_i);

  ss_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(share_clk_i), .tick_o(tick));

  ss_delay_cnt #(.TW(TW)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear_i(state_q != SS_DELAY),
    .tick_i(tick), .limit_i(dly_l), .expired_o(dly_expired));

  ss_ramp_acc #(.VW(VW), .TW(TW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(acc_clear), .jump_i(acc_jump),
    .load_i(acc_load), .step_i(acc_step), .vset_i(vset_l),
    .steps_i(rise_l), .target_o(vtarget_o), .last_o(last_step));

  assign abort_run = !en_i || !run_i;

  always_comb begin
    state_d   = state_q;
    acc_clear = 1'b0;
    acc_jump  = 1'b0;
    acc_load  = 1'b0;
    acc_step  = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      SS_IDLE: begin
        acc_clear = 1'b1;
        if (en_i) state_d = SS_WAIT;
      end
      SS_WAIT: begin
        if (!en_i) begin
          state_d = SS_IDLE; acc_clear = 1'b1;
        end else if (run_i) begin
          state_d = SS_DELAY;
        end
      end
      SS_DELAY: begin
        if (abort_run) begin
          state_d = SS_IDLE; acc_clear = 1'b1;
        end else if (dly_expired) begin
          if (rise_l < MIN_RISE_C) begin
            state_d = SS_ON; acc_jump = 1'b1; done_d = 1'b1;
          end else begin
            state_d = SS_RAMP; acc_load = 1'b1;
          end
        end
      end
      SS_RAMP: begin
        if (abort_run) begin
          state_d = SS_IDLE; acc_clear = 1'b1;
        end else if (tick) begin
          acc_step = 1'b1;
          if (last_step) begin
            state_d = SS_ON; done_d = 1'b1;
          end
        end
      end
      SS_ON: begin
        if (abort_run) begin
          state_d = SS_IDLE; acc_clear = 1'b1;
        end
      end
      default: begin
        state_d = SS_IDLE; acc_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      done_q  <= 1'b0;
      dly_l   <= '0;
      rise_l  <= '0;
      vset_l  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (state_q == SS_IDLE && en_i) begin
        dly_l  <= dly_cfg_i;
        rise_l <= rise_cfg_i;
        vset_l <= vset_cfg_i;
      end
    end
  end

  assign ramp_active_o = (state_q == SS_RAMP);
  assign dcm_req_o     = (state_q == SS_RAMP);
  assign done_o        = done_q;

  // R9
  done_at_setpoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> vtarget_o == vset_l);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  enable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (vtarget_o == '0 && !ramp_active_o));

  // R5
  ramp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_active_o && $past(ramp_active_o) && vtarget_o != $past(vtarget_o))
      |-> $past(tick));

  // R2
  wait_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_WAIT) |-> (vtarget_o == '0 && !ramp_active_o));

endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, init_done = 0, vin_ok = 0, share_clk = 0, peer_hold = 0;
  logic [15:0] dly_cfg = 0, rise_cfg = 0, vset_cfg = 0;
  logic run_pull_low, ramp_active, dcm_req, done;
  logic [15:0] vtarget;
  logic run_line;

  int total = 0, bad = 0, cycles = 0;
  bit ramp_seen = 0;

  always #10 clk = ~clk;

  assign run_line = !run_pull_low && !peer_hold;

  softstart_seq u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .init_done_i(init_done),
    .vin_ok_i(vin_ok), .run_i(run_line), .share_clk_i(share_clk),
    .dly_cfg_i(dly_cfg), .rise_cfg_i(rise_cfg), .vset_cfg_i(vset_cfg),
    .run_pull_low_o(run_pull_low), .vtarget_o(vtarget),
    .ramp_active_o(ramp_active), .dcm_req_o(dcm_req), .done_o(done));

  // shared timebase: 3 clocks high, 3 low
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      share_clk = ~share_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference: 0 idle, 1 wait, 2 delay, 3 ramp, 4 on
  int m_st = 0, m_cnt = 0, m_k = 0;
  longint m_tgt = 0, m_dly = 0, m_rise = 0, m_vset = 0;
  bit m_done = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always @(posedge clk) begin
    bit tk;
    bit abort;
    tk = m_s2 && !m_s3;
    abort = !en || !run_line;
    m_done = 0;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_k = 0; m_tgt = 0;
      m_dly = 0; m_rise = 0; m_vset = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      case (m_st)
        0: begin
          m_tgt = 0;
          if (en) begin
            m_dly = dly_cfg; m_rise = rise_cfg; m_vset = vset_cfg; m_st = 1;
          end
        end
        1: if (!en) begin m_st = 0; m_tgt = 0; end
           else if (run_line) begin m_st = 2; m_cnt = 0; end
        2: if (abort) begin m_st = 0; m_tgt = 0; end
           else if (m_cnt == m_dly) begin
             if (m_rise < 3) begin m_st = 4; m_tgt = m_vset; m_done = 1; end
             else begin m_st = 3; m_k = 0; m_tgt = 0; end
           end else if (tk) m_cnt++;
        3: if (abort) begin m_st = 0; m_tgt = 0; end
           else if (tk) begin
             m_k++;
             m_tgt = (m_vset * m_k) / m_rise;
             if (m_k == m_rise) begin m_st = 4; m_done = 1; end
           end
        default: if (abort) begin m_st = 0; m_tgt = 0; end
      endcase
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = share_clk;
    end
  end

  // cycle-by-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    cycles++;
    if (rst_n) begin
      chk(vtarget == m_tgt, "R5 vtarget", vtarget, m_tgt);
      chk(ramp_active == (m_st == 3), "R8 ramp_active", ramp_active, m_st == 3);
      chk(dcm_req == (m_st == 3), "R8 dcm_req", dcm_req, m_st == 3);
      chk(done == m_done, "R9 done", done, m_done);
      chk(run_pull_low == !(init_done && vin_ok), "R1 pull_low", run_pull_low, !(init_done && vin_ok));
      if (ramp_active) ramp_seen = 1;
    end
    if (cycles > 190000) begin
      chk(0, "watchdog", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input int maxc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic start(input int d, input int r, input int v);
    dly_cfg = 16'(d); rise_cfg = 16'(r); vset_cfg = 16'(v);
    en = 1;
  endtask

  initial begin
    bit seen;
    cyc(3);
    // reset state
    chk(vtarget == 0, "R10 reset vtarget", vtarget, 0);
    chk(run_pull_low == 1, "R1 reset pull_low", run_pull_low, 1);
    rst_n = 1;
    cyc(2);
    init_done = 1; cyc(1);
    chk(run_pull_low == 1, "R1 vin low", run_pull_low, 1);
    vin_ok = 1; cyc(1);
    chk(run_pull_low == 0, "R1 released", run_pull_low, 0);

    // R2: peer holds line, nothing starts
    peer_hold = 1;
    start(2, 10, 1003);
    cyc(40);
    chk(vtarget == 0 && !ramp_active, "R2 waits for line", vtarget, 0);
    peer_hold = 0;
    cyc(20);
    // R11: config change after idle exit
    vset_cfg = 5; rise_cfg = 2; dly_cfg = 0;
    ramp_seen = 0;
    wait_done(2000, seen);
    chk(seen, "R9 done seen", seen, 1);
    chk(vtarget == 1003, "R6 R11 final target", vtarget, 1003);
    cyc(1);
    chk(!done, "R9 done one cycle", done, 0);
    chk(ramp_seen, "R8 ramp seen", ramp_seen, 1);

    // R10: enable drop
    en = 0; cyc(1);
    cyc(1);
    chk(vtarget == 0, "R10 enable abort", vtarget, 0);

    // R7: rise 2 skips the ramp
    ramp_seen = 0;
    start(0, 2, 500);
    wait_done(500, seen);
    chk(seen && vtarget == 500, "R7 jump", vtarget, 500);
    chk(!ramp_seen, "R7 no ramp", ramp_seen, 0);
    en = 0; cyc(3);

    // R5 boundary: rise 3 ramps
    ramp_seen = 0;
    start(1, 3, 7);
    wait_done(500, seen);
    chk(seen && vtarget == 7, "R6 rise3 final", vtarget, 7);
    chk(ramp_seen, "R5 rise3 ramps", ramp_seen, 1);
    en = 0; cyc(3);

    // R10: line drops mid-ramp
    start(0, 40, 65535);
    cyc(100);
    chk(ramp_active, "R8 mid ramp", ramp_active, 1);
    peer_hold = 1; cyc(1);
    cyc(1);
    chk(vtarget == 0 && !ramp_active, "R10 line abort", vtarget, 0);
    peer_hold = 0; en = 0; cyc(3);

    // R3 R4: long ramp full-scale with delay
    start(5, 1000, 65535);
    wait_done(7000, seen);
    chk(seen && vtarget == 65535, "R6 full scale", vtarget, 65535);
    en = 0; cyc(3);

    // R4: zero delay, small fractional ramp
    start(0, 7, 5);
    wait_done(200, seen);
    chk(seen && vtarget == 5, "R4 R5 frac ramp", vtarget, 5);
    en = 0; cyc(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule